// File: doc/BRIEF.md
# Fifth-Order One-Bit Noise-Shaping Modulator

This block turns a stream of signed fixed-point samples into a one-bit stream whose local average follows the input. It runs at the oversampled rate, for example 64 times the output word rate, so about 2.822 MHz for a 44.1 kHz audio path. The quantization error is pushed out of the signal band, and a decimation filter placed after the block removes it.

The loop filter is a chain of five delaying integrators. Their gains are powers of two. A weighted sum of the five states drives a sign comparator. Two small feedback paths act as resonators and move noise-transfer zeros into the band. The output bit returns to the first integrator as plus or minus a programmable DAC level. A watchdog watches for a long run of equal output bits. When it finds one, it raises a one-cycle flag and clears every integrator on the next clock.

Top module: `sdm5_modulator`

## Requirements
- R1: A synchronous active-high reset clears all five integrator states, `bit_valid`, `bit_out` and `overload`. The first sample after reset therefore sees a weighted sum of exactly zero.
- R2: `bit_valid` is `in_valid` delayed by one clock. A cycle with `in_valid` low leaves `bit_out` and every integrator state unchanged.
- R3: The output bit is 1 (meaning +1) when the weighted sum of the integrator states before the update is zero or positive, and 0 (meaning -1) when that sum is negative. The bit is registered, so it appears one clock after its sample.
- R4: There are five integrators, each holding a 24-bit two's-complement state with 16 fractional bits. Each adds its input, arithmetically shifted right by 0, 0, 1, 2 and 3 for stages 1 to 5, to its state. Stages 2 to 5 take the state of the stage before them as input. The sum weights the states by right shifts of 0, 1, 2, 3 and 3.
- R5: The first stage input loses the stage-2 state shifted right by 10. The third stage input loses the stage-4 state shifted right by 4, minus the same state shifted right by 6.
- R6: The first stage input is the sample minus the fed-back level. That level is +DAC_LEVEL for an output 1 and -DAC_LEVEL for an output 0, with a default of 1.0 (65536).
- R7: Every integrator clamps to the range -8388608 to 8388607 and never wraps.
- R8: When 64 consecutive valid output bits are equal, `overload` rises together with the 64th bit and stays high for exactly one cycle.
- R9: On the clock after `overload` is high, all integrators are cleared and the run count restarts from zero. A sample accepted in that cycle still produces its bit, computed from the states before the clear. Its integration is dropped and it does not count toward a run.
- R10: With a DC input of 1/8 full scale (8192), the mean of the first 4096 output values (±1), taken from reset, lies within 0.01 of 0.125.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 24 | Signed sample, 16 fractional bits |
| bit_out | output | 1 | Output bit, 1 = +1, 0 = -1 |
| bit_valid | output | 1 | Marks a new output bit |
| overload | output | 1 | One-cycle instability flag |

## Verification
Two events can meet in the same cycle: the watchdog's integrator clear, and the acceptance of a new sample. The sample still needs its bit, while its state update must be thrown away. The bench drives a huge DC input so the loop saturates and trips the watchdog again and again. Each time the flag appears, the bench alternates between supplying a sample and holding `in_valid` low in the clearing cycle. A behavioural model predicts the bit, the valid strobe and the flag every clock, so any disagreement in either case shows up at once.

// File: rtl/sdm5_pkg.sv
package sdm5_pkg;
  localparam int NSTAGE = 5;

  // integrator gain as right shift: 1, 1, 1/2, 1/4, 1/8
  function automatic int gain_shift(input int idx);
    case (idx)
      0, 1:    return 0;
      2:       return 1;
      3:       return 2;
      default: return 3;
    endcase
  endfunction

  // summing weight as right shift: 1, 1/2, 1/4, 1/8, 1/8
  function automatic int weight_shift(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/sdm5_integ.sv
module sdm5_integ #(
  parameter int W     = 24,
  parameter int UW    = 28,
  parameter int SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [UW-1:0] u,
  output logic signed [W-1:0]  st
);
  localparam int EW = UW + 2;
  localparam logic signed [EW-1:0] HI = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0] LO = {{(EW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [W-1:0]  HI_W = HI[W-1:0];
  localparam logic signed [W-1:0]  LO_W = LO[W-1:0];

  logic signed [EW-1:0] step;
  logic signed [EW-1:0] sum;
  logic signed [W-1:0]  nxt;

  always_comb begin
    step = EW'(u >>> SHIFT);
    sum  = EW'(st) + step;
    if (sum > HI)      nxt = HI_W;
    else if (sum < LO) nxt = LO_W;
    else               nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  st <= '0;
    else if (en)     st <= nxt;
  end

  // R7: a state at a rail with an input pushing outward stays at the rail
  a_r7_hold_high: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && st == HI_W && !u[UW-1]) |=> (st == HI_W));
  a_r7_hold_low: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && st == LO_W && u[UW-1]) |=> (st == LO_W));
endmodule

// File: rtl/sdm5_feedback.sv
module sdm5_feedback
  import sdm5_pkg::*;
#(
  parameter int W         = 24,
  parameter int UW        = 28,
  parameter int DAC_LEVEL = 65536,
  parameter int RES1_SH   = 10,
  parameter int RES2_HI   = 4,
  parameter int RES2_LO   = 6
) (
  input  logic signed [W-1:0]  x,
  input  logic                 fb_pos,
  input  logic signed [W-1:0]  st [NSTAGE],
  output logic signed [UW-1:0] u  [NSTAGE]
);
  localparam logic signed [UW-1:0] LEVEL = UW'(DAC_LEVEL);

  logic signed [UW-1:0] dac;
  logic signed [UW-1:0] res1;
  logic signed [UW-1:0] res2;

  always_comb begin
    dac  = fb_pos ? LEVEL : -LEVEL;
    res1 = UW'(st[1] >>> RES1_SH);
    res2 = UW'(st[3] >>> RES2_HI) - UW'(st[3] >>> RES2_LO);
    u[0] = UW'(x) - dac - res1;
    u[2] = UW'(st[1]) - res2;
  end

  // plain chain links
  for (genvar i = 1; i < NSTAGE; i++) begin : g_chain
    if (i != 2) begin : g_link
      assign u[i] = UW'(st[i-1]);
    end
  end
endmodule

// File: rtl/sdm5_quantizer.sv
module sdm5_quantizer
  import sdm5_pkg::*;
#(
  parameter int W = 24
) (
  input  logic signed [W-1:0] st [NSTAGE],
  output logic                q_pos
);
  localparam int QW = W + 3;

  logic signed [QW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NSTAGE; i++) begin
      acc = acc + QW'(st[i] >>> weight_shift(i));
    end
    q_pos = ~acc[QW-1];
  end
endmodule

// File: rtl/sdm5_watchdog.sv
module sdm5_watchdog #(
  parameter int RUN_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic bit_now,
  output logic overload
);
  localparam int CW = $clog2(RUN_LIMIT + 1);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] nxt_run;
  logic          last_bit;
  logic          have_prev;

  always_comb begin
    if (have_prev && bit_now == last_bit) nxt_run = run_cnt + 1'b1;
    else                                  nxt_run = CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt   <= '0;
      last_bit  <= 1'b0;
      have_prev <= 1'b0;
      overload  <= 1'b0;
    end else if (overload) begin
      run_cnt   <= '0;
      have_prev <= 1'b0;
      overload  <= 1'b0;
    end else if (valid) begin
      run_cnt   <= nxt_run;
      last_bit  <= bit_now;
      have_prev <= 1'b1;
      overload  <= (nxt_run == CW'(RUN_LIMIT));
    end
  end

  // R8: the flag is a single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    overload |=> !overload);
  // R9: the run count restarts after the flag
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    overload |=> (run_cnt == '0 && !have_prev));
endmodule

// File: rtl/sdm5_modulator.sv
module sdm5_modulator
  import sdm5_pkg::*;
#(
  parameter int W         = 24,
  parameter int FRAC      = 16,
  parameter int DAC_LEVEL = 1 << FRAC,
  parameter int RUN_LIMIT = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_sample,
  output logic                bit_out,
  output logic                bit_valid,
  output logic                overload
);
  localparam int UW = W + 4;

  logic signed [W-1:0]  st [NSTAGE];
  logic signed [UW-1:0] u  [NSTAGE];
  logic                 q_pos;
  logic                 integ_en;

  assign integ_en = in_valid && !overload;

  sdm5_quantizer #(.W(W)) i_quant (
    .st    (st),
    .q_pos (q_pos)
  );

  sdm5_feedback #(.W(W), .UW(UW), .DAC_LEVEL(DAC_LEVEL)) i_fb (
    .x      (in_sample),
    .fb_pos (q_pos),
    .st     (st),
    .u      (u)
  );

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    sdm5_integ #(.W(W), .UW(UW), .SHIFT(gain_shift(i))) i_integ (
      .clk (clk),
      .rst (rst),
      .en  (integ_en),
      .clr (overload),
      .u   (u[i]),
      .st  (st[i])
    );

    // R9: every state is zero on the clock after the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
      overload |=> (st[i] == '0));
  end

  sdm5_watchdog #(.RUN_LIMIT(RUN_LIMIT)) i_wd (
    .clk      (clk),
    .rst      (rst),
    .valid    (in_valid),
    .bit_now  (q_pos),
    .overload (overload)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= in_valid;
      if (in_valid) bit_out <= q_pos;
    end
  end

  // R1: reset leaves outputs quiet
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!bit_valid && !bit_out && !overload));
  // R2: strobe follows the sample strobe by one clock
  a_r2_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> bit_valid);
  a_r2_novalid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !bit_valid);
  // R2: idle cycles hold the output bit and the first state
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !overload) |=> ($stable(bit_out) && $stable(st[0])));
endmodule

// File: tb/test_sdm5_modulator.sv
module test_sdm5_modulator;
  localparam int  RUN   = 64;
  localparam longint LVL = 65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic signed [23:0] in_sample = '0;
  logic        bit_out, bit_valid, overload;

  int nchk = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  sdm5_modulator i_sdm5_modulator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .bit_out(bit_out), .bit_valid(bit_valid), .overload(overload)
  );

  // behavioural reference
  longint ms [5];
  bit m_bit, m_bv, m_ov, m_have, m_last;
  int m_run;

  function automatic longint clampv(longint v);
    if (v > 8388607)  return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) ms[i] = 0;
    m_bit = 0; m_bv = 0; m_ov = 0; m_have = 0; m_last = 0; m_run = 0;
  endtask

  task automatic model_step(bit v, longint x);
    longint q, fb;
    longint uu [5];
    longint ns [5];
    bit b;
    int nr;
    q = ms[0] + (ms[1] >>> 1) + (ms[2] >>> 2) + (ms[3] >>> 3) + (ms[4] >>> 3);
    b = (q >= 0);
    m_bv = v;
    if (v) m_bit = b;
    if (m_ov) begin
      for (int i = 0; i < 5; i++) ms[i] = 0;
      m_run = 0; m_have = 0; m_ov = 0;
    end else if (v) begin
      fb = b ? LVL : -LVL;
      uu[0] = x - fb - (ms[1] >>> 10);
      uu[1] = ms[0];
      uu[2] = ms[1] - ((ms[3] >>> 4) - (ms[3] >>> 6));
      uu[3] = ms[2];
      uu[4] = ms[3];
      ns[0] = clampv(ms[0] + uu[0]);
      ns[1] = clampv(ms[1] + uu[1]);
      ns[2] = clampv(ms[2] + (uu[2] >>> 1));
      ns[3] = clampv(ms[3] + (uu[3] >>> 2));
      ns[4] = clampv(ms[4] + (uu[4] >>> 3));
      for (int i = 0; i < 5; i++) ms[i] = ns[i];
      nr = (m_have && b == m_last) ? m_run + 1 : 1;
      m_run = nr; m_last = b; m_have = 1;
      m_ov = (nr == RUN);
    end
  endtask

  task automatic check(string tag, logic act, logic exp, string what);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, longint x, string tag);
    in_valid  = v;
    in_sample = x[23:0];
    @(posedge clk);
    model_step(v, x);
    #5;
    nchk++;
    if (bit_valid !== m_bv || overload !== m_ov || bit_out !== m_bit) begin
      nbad++;
      $display("FAIL %s valid/bit/flag act=%b%b%b exp=%b%b%b",
               tag, bit_valid, bit_out, overload, m_bv, m_bit, m_ov);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    model_reset();
    #5 rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: run hung act=running exp=finished");
    finish_run();
  end

  initial begin
    int ones;
    int pulses;
    bit prev_ov;
    bit tog;
    bit v;
    model_reset();
    do_reset();
    // R1: reset state
    check("R1", bit_valid, 1'b0, "bit_valid after reset");
    check("R1", overload, 1'b0, "overload after reset");
    check("R1", bit_out, 1'b0, "bit_out after reset");

    // R2: idle cycles produce nothing
    for (int i = 0; i < 5; i++) cyc(0, 0, "R2");

    // R3: zero sum from cleared states gives +1
    cyc(1, 8192, "R3");
    check("R3", bit_out, 1'b1, "first bit from zero states");
    do_reset();

    // R4 / R10: DC of 1/8 full scale
    ones = 0;
    for (int i = 0; i < 4096; i++) begin
      cyc(1, 8192, "R4");
      if (bit_out) ones++;
    end
    nchk++;
    if ((2 * ones - 4608) > 40 || (2 * ones - 4608) < -40) begin
      nbad++;
      $display("FAIL R10 mean act=%0d/4096 ones exp=2304+-20", ones);
    end

    // R2: idle gap holds the output
    for (int i = 0; i < 4; i++) cyc(0, 0, "R2");

    // R5: negative DC with gaps
    for (int i = 0; i < 3000; i++) cyc((i % 3) != 2, -19661, "R5");

    // R6: slow ramp across +-1.0
    for (int i = 0; i < 2000; i++) cyc(1, -65536 + i * 65, "R6");

    // R8 / R9: large input trips the watchdog; alternate sample in clear cycle
    pulses = 0; prev_ov = 0; tog = 0;
    for (int i = 0; i < 800; i++) begin
      v = 1;
      if (overload) begin tog = ~tog; v = tog; end
      cyc(v, 6553600, "R9");
      if (overload) begin
        pulses++;
        check("R8", prev_ov, 1'b0, "flag longer than one cycle");
      end
      prev_ov = overload;
    end
    nchk++;
    if (pulses < 2) begin
      nbad++;
      $display("FAIL R8 flag pulses act=%0d exp>=2", pulses);
    end

    // R7: negative rail
    for (int i = 0; i < 400; i++) cyc(1, -8388608, "R7");

    // R1: reset mid-run
    do_reset();
    check("R1", bit_valid, 1'b0, "bit_valid after mid-run reset");
    check("R1", overload, 1'b0, "overload after mid-run reset");
    cyc(1, 0, "R1");
    check("R1", bit_out, 1'b1, "first bit after mid-run reset");
    for (int i = 0; i < 200; i++) cyc(1, 8192, "R4");

    finish_run();
  end
endmodule